// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block sequences the two reduced-power modes of an 8051-style microcontroller core. Software raises a one-cycle request to enter idle or power-down. In idle the CPU clock is gated while the oscillator and the peripherals keep running. In power-down the oscillator enable is also dropped, so the instruction that made the request is the last one executed. The block watches the two external interrupt pins, using their enable and level/edge configuration, together with any other pending interrupt, an oscillator-stable input and the reset pin. From these it decides when and how each mode ends.

Idle ends on any enabled interrupt, or on the reset pin. On a reset exit the CPU runs again at once, but writes to internal RAM are blocked until the qualified internal reset takes over. Power-down ends only on a qualified reset, or on an external interrupt that is both enabled and level-sensitive. Holding that pin low restarts the oscillator. Releasing it high finishes the exit, but only once the oscillator reports stable. On that exit the block sends a wake request and the source code to the interrupt logic.

While a mode is active, the block also drives override controls for the ALE and PSEN strobes and for ports 0 and 2. These depend on the mode and on whether code runs from internal or external program memory.

Top module: `lp_power_ctrl`

## Requirements
- R1: After synchronous reset the block is in run mode: cpu_clk_en=1, osc_run=1, pin_ovr=0, wake_req=0, core_rst=0, ram_wr_block=0.
- R2: In run mode with core_rst low, an idle_req pulse drops cpu_clk_en from the next cycle while osc_run stays 1.
- R3: In idle, a wake source gives one wake_req pulse of one cycle with wake_vec, and cpu_clk_en returns to 1 in the same cycle. The wake sources are an enabled external pin that is low (int_level=1, level mode) or has just fallen (int_level=0, edge mode), or other_irq. wake_vec is 0 for pin 0, 1 for pin 1 and 2 for other_irq, and the lowest index wins. A disabled pin, or an edge-mode pin that is already low, does not wake.
- R4: In run mode a pdown_req pulse enters power-down, with cpu_clk_en=0 and osc_run=0. pdown_req wins over a simultaneous idle_req.
- R5: In power-down only a pin with int_en=1 and int_level=1 that is driven low raises osc_run. A disabled pin or an edge-mode pin leaves osc_run at 0.
- R6: After a power-down wake has started, the rising edge of that pin completes the exit only if osc_stable=1. The exit gives wake_req with the pin's code, and cpu_clk_en goes to 1. A release while osc_stable=0 is ignored, and the block stays with cpu_clk_en=0 and osc_run=1.
- R7: core_rst rises after rst_pin has been high for CLK_PER_MC*RST_MC consecutive clocks with osc_run and osc_stable both high. A shorter pulse never raises it.
- R8: When rst_pin rises in idle, cpu_clk_en returns to 1 and ram_wr_block is 1 until the cycle after core_rst rises. ram_wr_block then returns to 0.
- R9: Pin overrides follow the mode and ext_exec. In run mode: pin_ovr=0, p0_float=0, p2_addr=0. In idle: pin_ovr=1, ale_lvl=1, psen_lvl=1, p0_float=ext_exec, p2_addr=ext_exec. In power-down: pin_ovr=1, ale_lvl=0, psen_lvl=0, p0_float=ext_exec, p2_addr=0.
- R10: rst_pin high during power-down sets osc_run=1 at once. The reset count starts only once osc_stable is 1, and the qualified reset then returns the block to run mode.
- R11: While core_rst is high the block stays in run mode, and idle and power-down requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| idle_req | input | 1 | Software request to enter idle |
| pdown_req | input | 1 | Software request to enter power-down |
| int_en | input | NUM_EXT | Enable for each external interrupt |
| int_level | input | NUM_EXT | 1 = level-sensitive, 0 = falling edge |
| int_pin_n | input | NUM_EXT | External interrupt pins, active low |
| other_irq | input | 1 | Any other enabled interrupt pending |
| osc_stable | input | 1 | Oscillator has settled |
| rst_pin | input | 1 | Raw reset pin, active high |
| ext_exec | input | 1 | 1 when executing from external program memory |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Qualified internal reset |
| ram_wr_block | output | 1 | Block internal RAM writes |
| wake_req | output | 1 | One-cycle wake request to the interrupt logic |
| wake_vec | output | $clog2(NUM_EXT+1) | Wake source code |
| pin_ovr | output | 1 | ALE and PSEN are forced to the levels below |
| ale_lvl | output | 1 | Forced ALE level |
| psen_lvl | output | 1 | Forced PSEN level |
| p0_float | output | 1 | Port 0 drivers off |
| p2_addr | output | 1 | Port 2 shows the address instead of its latch |

## Verification
Two events can arrive together. In idle, an interrupt can fire on the same edge that the reset pin rises. During power-down wake-up, a pin release can come while the oscillator is still unstable. The bench provokes the first with pulses on rst_pin and other_irq. It then checks that the reset path takes the CPU back with RAM writes blocked, and that the cycle in which the qualified reset takes over is exact. For the second, the bench releases the pin before and after osc_stable rises, and accepts a wake pulse only in the stable case.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [2:0] {
        M_RUN,
        M_IDLE,
        M_IDLE_RST,
        M_PD,
        M_PD_WAKE
    } lp_mode_e;

    typedef struct packed {
        logic ovr;
        logic ale;
        logic psen;
        logic p0_float;
        logic p2_addr;
    } pin_ctl_t;

    // Strobe and port override per mode and program source
    function automatic pin_ctl_t pin_ctl(lp_mode_e m, logic ext);
        pin_ctl_t p;
        p = '0;
        case (m)
            M_IDLE: begin
                p.ovr      = 1'b1;
                p.ale      = 1'b1;
                p.psen     = 1'b1;
                p.p0_float = ext;
                p.p2_addr  = ext;
            end
            M_PD, M_PD_WAKE: begin
                p.ovr      = 1'b1;
                p.p0_float = ext;
            end
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic cpu_runs(lp_mode_e m);
        return (m == M_RUN) || (m == M_IDLE_RST);
    endfunction

endpackage

// File: rtl/lp_rst_qual.sv
module lp_rst_qual #(
    parameter int LIM = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin,
    input  logic osc_ok,
    output logic core_rst
);
    localparam int CW = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!(rst_pin && osc_ok)) begin
            cnt <= '0;
        end else if (cnt != CW'(LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign core_rst = (cnt == CW'(LIM));

    // R7
    reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(rst_pin));

endmodule

// File: rtl/lp_irq_cond.sv
module lp_irq_cond #(
    parameter int NUM_EXT = 2,
    parameter int VW      = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] int_en,
    input  logic [NUM_EXT-1:0] int_level,
    input  logic [NUM_EXT-1:0] int_pin_n,
    input  logic               other_irq,
    output logic               idle_wake,
    output logic [VW-1:0]      idle_vec,
    output logic [NUM_EXT-1:0] pd_hold,
    output logic [NUM_EXT-1:0] pd_release
);
    logic [NUM_EXT-1:0] pin_prev;
    logic [NUM_EXT-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) pin_prev <= '1;
        else     pin_prev <= int_pin_n;
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
        logic fall;
        assign fall          = pin_prev[i] & ~int_pin_n[i];
        assign hit[i]        = int_en[i] & (int_level[i] ? ~int_pin_n[i] : fall);
        assign pd_hold[i]    = int_en[i] & int_level[i] & ~int_pin_n[i];
        assign pd_release[i] = ~pin_prev[i] & int_pin_n[i];
    end

    always_comb begin
        idle_wake = (|hit) | other_irq;
        idle_vec  = VW'(NUM_EXT);
        for (int i = NUM_EXT - 1; i >= 0; i--) begin
            if (hit[i]) idle_vec = VW'(i);
        end
    end

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
    import lp_pkg::*;
#(
    parameter int NUM_EXT = 2,
    parameter int VW      = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               core_rst,
    input  logic               idle_req,
    input  logic               pdown_req,
    input  logic               rst_pin,
    input  logic               osc_stable,
    input  logic               idle_wake,
    input  logic [VW-1:0]      idle_vec,
    input  logic [NUM_EXT-1:0] pd_hold,
    input  logic [NUM_EXT-1:0] pd_release,
    output lp_mode_e           mode,
    output logic               wake_req,
    output logic [VW-1:0]      wake_vec,
    output logic               osc_run
);
    lp_mode_e      mode_nxt;
    logic [VW-1:0] src_q, src_nxt, vec_nxt, pd_first;
    logic          wk_nxt, complete;

    always_comb begin
        pd_first = '0;
        for (int i = NUM_EXT - 1; i >= 0; i--) begin
            if (pd_hold[i]) pd_first = VW'(i);
        end
        complete = 1'b0;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (src_q == VW'(i)) complete = osc_stable & pd_release[i];
        end
    end

    always_comb begin
        mode_nxt = mode;
        wk_nxt   = 1'b0;
        vec_nxt  = wake_vec;
        src_nxt  = src_q;
        if (core_rst) begin
            mode_nxt = M_RUN;
        end else begin
            case (mode)
                M_RUN: begin
                    if (pdown_req)     mode_nxt = M_PD;
                    else if (idle_req) mode_nxt = M_IDLE;
                end
                M_IDLE: begin
                    if (rst_pin) begin
                        mode_nxt = M_IDLE_RST;
                    end else if (idle_wake) begin
                        mode_nxt = M_RUN;
                        wk_nxt   = 1'b1;
                        vec_nxt  = idle_vec;
                    end
                end
                M_IDLE_RST: begin
                    if (!rst_pin) mode_nxt = M_RUN;
                end
                M_PD: begin
                    if (|pd_hold) begin
                        mode_nxt = M_PD_WAKE;
                        src_nxt  = pd_first;
                    end
                end
                M_PD_WAKE: begin
                    if (complete) begin
                        mode_nxt = M_RUN;
                        wk_nxt   = 1'b1;
                        vec_nxt  = src_q;
                    end
                end
                default: mode_nxt = M_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_RUN;
            wake_req <= 1'b0;
            wake_vec <= '0;
            src_q    <= '0;
        end else begin
            mode     <= mode_nxt;
            wake_req <= wk_nxt;
            wake_vec <= vec_nxt;
            src_q    <= src_nxt;
        end
    end

    assign osc_run = !((mode == M_PD) && !rst_pin);

    // R3
    wake_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(mode == M_IDLE || mode == M_PD_WAKE));

    // R6
    stable_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && $past(mode == M_PD_WAKE)) |-> $past(osc_stable));

    // R11
    reset_run_chk: assert property (@(posedge clk) disable iff (rst)
        $past(core_rst) |-> (mode == M_RUN));

endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
    import lp_pkg::*;
#(
    parameter int CLK_PER_MC = 12,
    parameter int RST_MC     = 2,
    parameter int NUM_EXT    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         idle_req,
    input  logic                         pdown_req,
    input  logic [NUM_EXT-1:0]           int_en,
    input  logic [NUM_EXT-1:0]           int_level,
    input  logic [NUM_EXT-1:0]           int_pin_n,
    input  logic                         other_irq,
    input  logic                         osc_stable,
    input  logic                         rst_pin,
    input  logic                         ext_exec,
    output logic                         cpu_clk_en,
    output logic                         osc_run,
    output logic                         core_rst,
    output logic                         ram_wr_block,
    output logic                         wake_req,
    output logic [$clog2(NUM_EXT+1)-1:0] wake_vec,
    output logic                         pin_ovr,
    output logic                         ale_lvl,
    output logic                         psen_lvl,
    output logic                         p0_float,
    output logic                         p2_addr
);
    localparam int RST_CLKS = CLK_PER_MC * RST_MC;
    localparam int VW       = $clog2(NUM_EXT + 1);

    lp_mode_e           mode;
    logic               idle_wake;
    logic [VW-1:0]      idle_vec;
    logic [NUM_EXT-1:0] pd_hold, pd_release;
    pin_ctl_t           pc;

    lp_rst_qual #(.LIM(RST_CLKS)) u_rst (
        .clk      (clk),
        .rst      (rst),
        .rst_pin  (rst_pin),
        .osc_ok   (osc_run & osc_stable),
        .core_rst (core_rst)
    );

    lp_irq_cond #(.NUM_EXT(NUM_EXT), .VW(VW)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .int_en     (int_en),
        .int_level  (int_level),
        .int_pin_n  (int_pin_n),
        .other_irq  (other_irq),
        .idle_wake  (idle_wake),
        .idle_vec   (idle_vec),
        .pd_hold    (pd_hold),
        .pd_release (pd_release)
    );

    lp_mode_fsm #(.NUM_EXT(NUM_EXT), .VW(VW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .core_rst   (core_rst),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .rst_pin    (rst_pin),
        .osc_stable (osc_stable),
        .idle_wake  (idle_wake),
        .idle_vec   (idle_vec),
        .pd_hold    (pd_hold),
        .pd_release (pd_release),
        .mode       (mode),
        .wake_req   (wake_req),
        .wake_vec   (wake_vec),
        .osc_run    (osc_run)
    );

    assign pc           = pin_ctl(mode, ext_exec);
    assign pin_ovr      = pc.ovr;
    assign ale_lvl      = pc.ale;
    assign psen_lvl     = pc.psen;
    assign p0_float     = pc.p0_float;
    assign p2_addr      = pc.p2_addr;
    assign cpu_clk_en   = cpu_runs(mode);
    assign ram_wr_block = (mode == M_IDLE_RST);

    // R8
    ram_block_run_chk: assert property (@(posedge clk) disable iff (rst)
        ram_wr_block |-> cpu_clk_en);

    // R9
    pd_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_run |-> (pin_ovr && !ale_lvl && !psen_lvl && !p2_addr));

endmodule

// File: tb/lp_power_ctrl_tb.sv
module lp_power_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idle_req = 0, pdown_req = 0, other_irq = 0;
    logic [1:0] int_en = '0, int_level = '0, int_pin_n = '1;
    logic       osc_stable = 1, rst_pin = 0, ext_exec = 0;
    logic       cpu_clk_en, osc_run, core_rst, ram_wr_block, wake_req;
    logic [1:0] wake_vec;
    logic       pin_ovr, ale_lvl, psen_lvl, p0_float, p2_addr;
    int         total = 0, bad = 0, cyc = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    lp_power_ctrl #(.CLK_PER_MC(2), .RST_MC(2), .NUM_EXT(2)) dut_i (
        .clk(clk), .rst(rst), .idle_req(idle_req), .pdown_req(pdown_req),
        .int_en(int_en), .int_level(int_level), .int_pin_n(int_pin_n),
        .other_irq(other_irq), .osc_stable(osc_stable), .rst_pin(rst_pin),
        .ext_exec(ext_exec), .cpu_clk_en(cpu_clk_en), .osc_run(osc_run),
        .core_rst(core_rst), .ram_wr_block(ram_wr_block), .wake_req(wake_req),
        .wake_vec(wake_vec), .pin_ovr(pin_ovr), .ale_lvl(ale_lvl),
        .psen_lvl(psen_lvl), .p0_float(p0_float), .p2_addr(p2_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic go_idle();
        idle_req = 1; tick(); idle_req = 0;
    endtask

    task automatic go_pd();
        pdown_req = 1; tick(); pdown_req = 0;
    endtask

    task automatic hw_reset();
        rst_pin = 1; osc_stable = 1; ticks(5); rst_pin = 0; tick();
    endtask

    // mode: 0 run, 1 idle, 2 power-down
    task automatic pin_sweep(input string tag, input int m);
        for (int e = 0; e < 2; e++) begin
            ext_exec = e[0]; #1;
            chk({tag, " ovr"},  pin_ovr,  (m != 0));
            chk({tag, " ale"},  ale_lvl,  (m == 1));
            chk({tag, " psen"}, psen_lvl, (m == 1));
            chk({tag, " p0"},   p0_float, (m != 0) && e == 1);
            chk({tag, " p2"},   p2_addr,  (m == 1) && e == 1);
        end
        ext_exec = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 cpu", cpu_clk_en, 1);
        chk("R1 osc", osc_run, 1);
        chk("R1 ovr", pin_ovr, 0);
        chk("R1 wake", wake_req, 0);
        chk("R1 core_rst", core_rst, 0);
        chk("R1 ram", ram_wr_block, 0);
        pin_sweep("R9 run", 0);

        // R2 idle entry
        go_idle();
        chk("R2 cpu", cpu_clk_en, 0);
        chk("R2 osc", osc_run, 1);
        pin_sweep("R9 idle", 1);

        // R3 other interrupt wakes idle
        other_irq = 1; tick(); other_irq = 0;
        chk("R3 other wake", wake_req, 1);
        chk("R3 other vec", wake_vec, 2);
        chk("R3 other cpu", cpu_clk_en, 1);
        tick();
        chk("R3 pulse one cycle", wake_req, 0);

        // R3 idle sweep over source, enable, level/edge
        for (int s = 0; s < 2; s++)
            for (int en = 0; en < 2; en++)
                for (int lv = 0; lv < 2; lv++) begin
                    int_en = 2'(en << s); int_level = 2'(lv << s);
                    go_idle();
                    int_pin_n[s] = 1'b0;
                    tick();
                    chk($sformatf("R3 idle s%0d en%0d lv%0d wake", s, en, lv), wake_req, en);
                    chk($sformatf("R3 idle s%0d en%0d lv%0d cpu", s, en, lv), cpu_clk_en, en);
                    if (en == 1) chk("R3 idle vec", wake_vec, s);
                    int_pin_n = '1;
                    if (en == 0) begin
                        other_irq = 1; tick(); other_irq = 0;
                        chk("R3 exit via other", wake_vec, 2);
                    end
                    tick();
                end

        // R3 edge-mode pin already low does not wake
        int_en = 2'b01; int_level = 2'b00; int_pin_n = 2'b10;
        tick();
        go_idle(); ticks(2);
        chk("R3 held low edge no wake", cpu_clk_en, 0);
        other_irq = 1; tick(); other_irq = 0;
        int_pin_n = '1; int_en = '0; tick();

        // R4 power-down priority over idle
        idle_req = 1; pdown_req = 1; tick(); idle_req = 0; pdown_req = 0;
        chk("R4 cpu", cpu_clk_en, 0);
        chk("R4 osc", osc_run, 0);
        pin_sweep("R9 pd", 2);

        // R10 reset exit from power-down
        osc_stable = 0; rst_pin = 1; #1;
        chk("R10 osc restart", osc_run, 1);
        ticks(5);
        chk("R10 no count unstable", core_rst, 0);
        osc_stable = 1; ticks(3);
        chk("R10 count short", core_rst, 0);
        tick();
        chk("R10 core_rst", core_rst, 1);
        tick();
        chk("R10 run", cpu_clk_en, 1);
        rst_pin = 0; tick();

        // R5 / R6 power-down wake sweep
        for (int s = 0; s < 2; s++)
            for (int en = 0; en < 2; en++)
                for (int lv = 0; lv < 2; lv++) begin
                    int exp_w;
                    exp_w = en & lv;
                    int_en = 2'(en << s); int_level = 2'(lv << s);
                    osc_stable = 1;
                    go_pd();
                    osc_stable = 0;
                    int_pin_n[s] = 1'b0;
                    tick();
                    chk($sformatf("R5 pd s%0d en%0d lv%0d osc", s, en, lv), osc_run, exp_w);
                    chk("R5 pd cpu off", cpu_clk_en, 0);
                    int_pin_n[s] = 1'b1;
                    tick();
                    if (exp_w == 1) begin
                        chk("R6 early release ignored", wake_req, 0);
                        chk("R6 still asleep", cpu_clk_en, 0);
                        chk("R6 osc kept", osc_run, 1);
                        int_pin_n[s] = 1'b0; osc_stable = 1;
                        tick();
                        int_pin_n[s] = 1'b1;
                        tick();
                        chk("R6 wake", wake_req, 1);
                        chk("R6 vec", wake_vec, s);
                        chk("R6 cpu", cpu_clk_en, 1);
                        tick();
                    end else begin
                        chk("R5 ignored stays off", osc_run, 0);
                        hw_reset();
                        chk("R5 reset exit", cpu_clk_en, 1);
                    end
                end
        int_en = '0; int_level = '0;

        // R7 qualification length
        rst_pin = 1; ticks(3);
        chk("R7 short pulse", core_rst, 0);
        rst_pin = 0; tick();
        chk("R7 after short", core_rst, 0);
        rst_pin = 1; ticks(4);
        chk("R7 qualified", core_rst, 1);

        // R11 requests ignored while reset held
        idle_req = 1; tick(); idle_req = 0;
        chk("R11 idle ignored", cpu_clk_en, 1);
        pdown_req = 1; tick(); pdown_req = 0;
        chk("R11 pd ignored", osc_run, 1);
        rst_pin = 0; tick();

        // R8 idle ended by reset, with interrupt at the same edge
        go_idle();
        rst_pin = 1; other_irq = 1; tick(); other_irq = 0;
        chk("R8 cpu resumes", cpu_clk_en, 1);
        chk("R8 ram blocked", ram_wr_block, 1);
        chk("R8 no wake on reset", wake_req, 0);
        ticks(3);
        chk("R8 core_rst", core_rst, 1);
        chk("R8 still blocked", ram_wr_block, 1);
        tick();
        chk("R8 unblocked", ram_wr_block, 0);
        chk("R8 run", cpu_clk_en, 1);
        rst_pin = 0; tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule